// File: doc/BRIEF.md
# Descriptor Ring DMA Fetch Controller

This block is the front end of one block-DMA channel. Buffer descriptors sit in memory as a ring of two-word entries. The block reads them through a simple request/acknowledge memory port and passes each data descriptor to an external data mover. The mover answers with done or error. The ring is closed in memory by a trailing link descriptor that points back to the start. The block follows that pointer and counts the link slot like any other entry.

Software programs the ring base address and then writes a new total into a free-running write-count doorbell. The channel runs while its own read count differs from that total. It reports run, abort and suspended state, and raises done, interrupt-on-finish and error events. These events are masked onto one interrupt line. Software can re-initialise the channel, or ask it to stop at the next descriptor boundary.

Register offsets (word index on `reg_addr`): 0 control, 1 status, 2 ring base, 3 write count, 4 read count, 5 interrupt status, 6 interrupt enable.

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset the status register (offset 1) reads 0, the read count (offset 4) and write count (offset 3) read 0, `irq` is low and `mem_req` is low.
- R2: A descriptor is fetched as word 0 at the fetch pointer and word 1 at pointer+4. A descriptor whose word 0 bits 31:29 equal 1 is a data descriptor. It is handed to the mover on `mv_hdr`/`mv_buf` and held until `mv_done`. The pointer then advances by 8 and the read count by 1.
- R3: A descriptor whose bits 31:29 equal 3 is a link. The fetch pointer is loaded from its word 1 with bits 2:0 cleared, no mover transfer takes place, and the read count advances by 1.
- R4: The channel runs (status bit 0) while the read count differs from the write count. When a completed descriptor makes them equal, it stops and sets interrupt status bit 0.
- R5: A data descriptor with word 0 bit 28 set raises interrupt status bit 1 when the mover reports done.
- R6: A mover error, or a fetched type other than 1 or 3, sets status bit 1 (abort) and interrupt status bit 2. It also clears run and leaves the read count unchanged. While aborted, a doorbell write starts no memory fetch.
- R7: Writing control bit 0 (offset 0) clears the read count, write count, ring base, fetch pointer, abort and suspended state. The base must then be written again before new work starts.
- R8: Writing control bit 1 lets the current descriptor finish, then clears run with work still pending. Status bit 2 reads 1, interrupt status bit 0 is not raised, and the next write to the write count resumes the channel.
- R9: A write-count write while a descriptor fetch is pending leaves `mem_req` and `mem_addr` unchanged. The channel carries on to the new total.
- R10: Interrupt status bits clear when 1 is written to them at offset 5. `irq` is the OR of the status bits ANDed with the enable bits at offset 6.
- R11: A write to the ring base (offset 2) while idle stores the value with bits 2:0 cleared and loads the fetch pointer; read-back shows the aligned value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge, one cycle, with data |
| mem_rdata | input | 32 | Read data valid with `mem_ack` |
| mv_valid | output | 1 | Data descriptor offered to the mover |
| mv_hdr | output | 32 | Descriptor word 0 |
| mv_buf | output | 32 | Descriptor word 1 (buffer address) |
| mv_done | input | 1 | Mover finished the descriptor |
| mv_err | input | 1 | Mover failed the descriptor |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach from the ports is a doorbell write that lands while a descriptor word read is still outstanding. The bench stretches the memory latency and waits until it sees the request pending. It then writes the new count and compares the request address before and after. The suspend case needs a similar setup: the mover latency is stretched so that the suspend lands mid-transfer. This shows that exactly one descriptor retires before the channel goes quiet. Wrap-around is reached by sending a count past the link slot. The link entry carries misaligned low address bits, which shows that alignment is applied to the pointer it loads.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned INT_N  = 3;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] RA_BASE  = 3'd2;
  localparam logic [REG_AW-1:0] RA_WRCNT = 3'd3;
  localparam logic [REG_AW-1:0] RA_RDCNT = 3'd4;
  localparam logic [REG_AW-1:0] RA_INTST = 3'd5;
  localparam logic [REG_AW-1:0] RA_INTEN = 3'd6;

  localparam int unsigned IB_DONE = 0;
  localparam int unsigned IB_IOF  = 1;
  localparam int unsigned IB_ERR  = 2;

  localparam int unsigned CB_INIT = 0;
  localparam int unsigned CB_SUSP = 1;

  localparam logic [2:0] KIND_DATA = 3'd1;
  localparam logic [2:0] KIND_LINK = 3'd3;
  localparam int unsigned IOF_BIT  = 28;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH_HDR,
    W_FETCH_PTR,
    W_DECODE,
    W_MOVE
  } walk_state_t;

  // clear the offset bits below the descriptor size
  function automatic logic [WORD_W-1:0] align_desc(input logic [WORD_W-1:0] a,
                                                   input int unsigned bytes);
    return a & ~(32'(bytes) - 32'd1);
  endfunction

  // write-one-to-clear with set priority
  function automatic logic [INT_N-1:0] w1c_merge(input logic [INT_N-1:0] cur,
                                                 input logic [INT_N-1:0] clr,
                                                 input logic [INT_N-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/dmaf_regs.sv
module dmaf_regs
  import dmaf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              run,
  input  logic              aborted,
  input  logic              held,
  input  logic [CNT_W-1:0]  rd_cnt,
  input  logic              ev_done,
  input  logic              ev_iof,
  input  logic              ev_err,
  output logic              init_req,
  output logic              susp_req,
  output logic              doorbell,
  output logic              base_load,
  output logic [ADDR_W-1:0] base_val,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic              irq
);

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  wr_q;
  logic [INT_N-1:0]  int_q;
  logic [INT_N-1:0]  en_q;
  logic [INT_N-1:0]  int_set;
  logic [INT_N-1:0]  int_clr;
  logic [WORD_W-1:0] aligned_w;

  assign aligned_w = align_desc(reg_wdata, DESC_BYTES);

  assign init_req  = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_INIT];
  assign susp_req  = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_SUSP] && !reg_wdata[CB_INIT];
  assign doorbell  = reg_we && (reg_addr == RA_WRCNT);
  assign base_load = reg_we && (reg_addr == RA_BASE) && !run;
  assign base_val  = aligned_w[ADDR_W-1:0];
  assign wr_cnt    = wr_q;

  always_comb begin
    int_set          = '0;
    int_set[IB_DONE] = ev_done;
    int_set[IB_IOF]  = ev_iof;
    int_set[IB_ERR]  = ev_err;
    int_clr          = (reg_we && (reg_addr == RA_INTST)) ? reg_wdata[INT_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      wr_q   <= '0;
      int_q  <= '0;
      en_q   <= '0;
    end else begin
      if (init_req) begin
        base_q <= '0;
        wr_q   <= '0;
      end else begin
        if (base_load) base_q <= base_val;
        if (doorbell)  wr_q   <= reg_wdata[CNT_W-1:0];
      end
      int_q <= w1c_merge(int_q, int_clr, int_set);
      if (reg_we && (reg_addr == RA_INTEN)) en_q <= reg_wdata[INT_N-1:0];
    end
  end

  assign irq = |(int_q & en_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_STAT:  reg_rdata = {29'd0, held, aborted, run};
      RA_BASE:  reg_rdata = WORD_W'(base_q);
      RA_WRCNT: reg_rdata = WORD_W'(wr_q);
      RA_RDCNT: reg_rdata = WORD_W'(rd_cnt);
      RA_INTST: reg_rdata = WORD_W'(int_q);
      RA_INTEN: reg_rdata = WORD_W'(en_q);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dmaf_walker.sv
module dmaf_walker
  import dmaf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              susp_req,
  input  logic              doorbell,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [CNT_W-1:0]  wr_cnt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mv_valid,
  output logic [WORD_W-1:0] mv_hdr,
  output logic [WORD_W-1:0] mv_buf,
  input  logic              mv_done,
  input  logic              mv_err,
  output logic              run,
  output logic              aborted,
  output logic              held,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              ev_done,
  output logic              ev_iof,
  output logic              ev_err
);

  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);
  localparam logic [ADDR_W-1:0] DESC_STEP  = ADDR_W'(DESC_BYTES);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  walk_state_t       state;
  logic [ADDR_W-1:0] ptr;
  logic [WORD_W-1:0] hdr_q;
  logic [WORD_W-1:0] buf_q;
  logic [CNT_W-1:0]  rd_q;
  logic              abort_q;
  logic              hold_q;

  logic [2:0]        kind;
  logic              dec_link, dec_bad, fin_ok, fin_bad;
  logic              complete, drained, stop;
  logic [CNT_W-1:0]  rd_next;
  logic [WORD_W-1:0] link_target;

  assign kind        = hdr_q[31:29];
  assign dec_link    = (state == W_DECODE) && (kind == KIND_LINK);
  assign dec_bad     = (state == W_DECODE) && (kind != KIND_LINK) && (kind != KIND_DATA);
  assign fin_bad     = (state == W_MOVE) && mv_err;
  assign fin_ok      = (state == W_MOVE) && mv_done && !mv_err;
  assign complete    = dec_link || fin_ok;
  assign rd_next     = bump(rd_q);
  assign drained     = (rd_next == wr_cnt);
  assign stop        = drained || hold_q || susp_req;
  assign link_target = align_desc(buf_q, DESC_BYTES);

  assign ev_done = complete && drained;
  assign ev_iof  = fin_ok && hdr_q[IOF_BIT];
  assign ev_err  = dec_bad || fin_bad;

  assign mem_req  = (state == W_FETCH_HDR) || (state == W_FETCH_PTR);
  assign mem_addr = ptr + ((state == W_FETCH_PTR) ? WORD_BYTES : '0);
  assign mv_valid = (state == W_MOVE);
  assign mv_hdr   = hdr_q;
  assign mv_buf   = buf_q;
  assign run      = (state != W_IDLE);
  assign aborted  = abort_q;
  assign held     = hold_q;
  assign rd_cnt   = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || init_req) begin
      state   <= W_IDLE;
      ptr     <= '0;
      hdr_q   <= '0;
      buf_q   <= '0;
      rd_q    <= '0;
      abort_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      if (susp_req)      hold_q <= 1'b1;
      else if (doorbell) hold_q <= 1'b0;
      unique case (state)
        W_IDLE: begin
          if (base_load) ptr <= base_val;
          if (!abort_q && !hold_q && (rd_q != wr_cnt)) state <= W_FETCH_HDR;
        end
        W_FETCH_HDR: begin
          if (mem_ack) begin
            hdr_q <= mem_rdata;
            state <= W_FETCH_PTR;
          end
        end
        W_FETCH_PTR: begin
          if (mem_ack) begin
            buf_q <= mem_rdata;
            state <= W_DECODE;
          end
        end
        W_DECODE: begin
          if (dec_link) begin
            ptr   <= link_target[ADDR_W-1:0];
            rd_q  <= rd_next;
            state <= stop ? W_IDLE : W_FETCH_HDR;
          end else if (dec_bad) begin
            abort_q <= 1'b1;
            state   <= W_IDLE;
          end else begin
            state <= W_MOVE;
          end
        end
        W_MOVE: begin
          if (fin_bad) begin
            abort_q <= 1'b1;
            state   <= W_IDLE;
          end else if (fin_ok) begin
            ptr   <= ptr + DESC_STEP;
            rd_q  <= rd_next;
            state <= stop ? W_IDLE : W_FETCH_HDR;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch
  import dmaf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              mv_valid,
  output logic [31:0]       mv_hdr,
  output logic [31:0]       mv_buf,
  input  logic              mv_done,
  input  logic              mv_err,
  output logic              irq
);

  logic              init_req, susp_req, doorbell, base_load;
  logic [ADDR_W-1:0] base_val;
  logic [CNT_W-1:0]  wr_cnt;
  logic [CNT_W-1:0]  rd_cnt;
  logic              run, aborted, held;
  logic              ev_done, ev_iof, ev_err;

  dmaf_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .run       (run),
    .aborted   (aborted),
    .held      (held),
    .rd_cnt    (rd_cnt),
    .ev_done   (ev_done),
    .ev_iof    (ev_iof),
    .ev_err    (ev_err),
    .init_req  (init_req),
    .susp_req  (susp_req),
    .doorbell  (doorbell),
    .base_load (base_load),
    .base_val  (base_val),
    .wr_cnt    (wr_cnt),
    .irq       (irq)
  );

  dmaf_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_req  (init_req),
    .susp_req  (susp_req),
    .doorbell  (doorbell),
    .base_load (base_load),
    .base_val  (base_val),
    .wr_cnt    (wr_cnt),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mv_valid  (mv_valid),
    .mv_hdr    (mv_hdr),
    .mv_buf    (mv_buf),
    .mv_done   (mv_done),
    .mv_err    (mv_err),
    .run       (run),
    .aborted   (aborted),
    .held      (held),
    .rd_cnt    (rd_cnt),
    .ev_done   (ev_done),
    .ev_iof    (ev_iof),
    .ev_err    (ev_err)
  );

endmodule

// File: rtl/dmaf_ring_chk.sv
module dmaf_ring_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_req,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mv_valid,
  input logic [31:0]       mv_hdr,
  input logic [31:0]       mv_buf,
  input logic              mv_done,
  input logic              mv_err,
  input logic              run,
  input logic              aborted,
  input logic [CNT_W-1:0]  rd_cnt,
  input logic              ev_done,
  input logic              ev_iof,
  input logic              ev_err
);

  p_abort_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> (!mem_req && !mv_valid));

  p_err_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !init_req) |=> (aborted && !run));

  p_events_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> (!ev_done && !ev_iof));

  p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !init_req) |=> (mem_req && $stable(mem_addr)));

  p_move_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_done && !mv_err && !init_req) |=>
      (mv_valid && $stable(mv_hdr) && $stable(mv_buf)));

  p_rd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (rd_cnt == $past(rd_cnt) || rd_cnt == $past(rd_cnt) + CNT_W'(1) || rd_cnt == '0));

  p_done_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !run);

  p_init_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (rd_cnt == '0 && !aborted && !run));

endmodule

bind desc_ring_fetch dmaf_ring_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .init_req (init_req),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .mv_valid (mv_valid),
  .mv_hdr   (mv_hdr),
  .mv_buf   (mv_buf),
  .mv_done  (mv_done),
  .mv_err   (mv_err),
  .run      (run),
  .aborted  (aborted),
  .rd_cnt   (rd_cnt),
  .ev_done  (ev_done),
  .ev_iof   (ev_iof),
  .ev_err   (ev_err)
);

// File: tb/tb_desc_ring_fetch.sv
`timescale 1ns/1ps
module tb_desc_ring_fetch;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_BASE = 3'd2, A_WRCNT = 3'd3,
                         A_RDCNT = 3'd4, A_INTST = 3'd5, A_INTEN = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mv_valid;
  logic [31:0] mv_hdr, mv_buf;
  logic        mv_done = 1'b0;
  logic        mv_err = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mem_lat = 2;
  int mv_lat = 2;
  bit force_err = 0;

  logic [31:0] mem [0:63];
  logic [31:0] mvl_buf [0:63];
  logic [31:0] mvl_hdr [0:63];
  int          mvl_n = 0;
  logic [31:0] flog [0:127];
  int          flog_n = 0;

  always #10 clk = ~clk;

  desc_ring_fetch dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_valid(mv_valid), .mv_hdr(mv_hdr), .mv_buf(mv_buf),
    .mv_done(mv_done), .mv_err(mv_err), .irq(irq)
  );

  // memory responder
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        cnt++;
        if (cnt >= mem_lat) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr[7:2]];
          if (flog_n < 128) flog[flog_n] = mem_addr;
          flog_n++;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  // data mover stub
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mv_done || mv_err) begin
        mv_done = 1'b0;
        mv_err = 1'b0;
        cnt = 0;
      end else if (mv_valid) begin
        cnt++;
        if (cnt >= mv_lat) begin
          if (force_err) mv_err = 1'b1;
          else begin
            mv_done = 1'b1;
            if (mvl_n < 64) begin
              mvl_hdr[mvl_n] = mv_hdr;
              mvl_buf[mvl_n] = mv_buf;
            end
            mvl_n++;
          end
        end
      end else begin
        cnt = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic load_ring();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[16] = 32'h2000_0010; mem[17] = 32'h0000_1000;   // slot 0 data
    mem[18] = 32'h2000_0020; mem[19] = 32'h0000_1100;   // slot 1 data
    mem[20] = 32'h3000_0030; mem[21] = 32'h0000_1200;   // slot 2 data, finish flag
    mem[22] = 32'h6000_0000; mem[23] = 32'h0000_0043;   // link, misaligned target
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d);  chk("R1 status", d, 32'h0);
    rd(A_RDCNT, d); chk("R1 read count", d, 32'h0);
    rd(A_WRCNT, d); chk("R1 write count", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'h0);
  endtask

  task automatic t_base_align();
    logic [31:0] d;
    wr(A_BASE, 32'h0000_0047);
    rd(A_BASE, d); chk("R11 base aligned", d, 32'h0000_0040);
  endtask

  task automatic t_single();
    logic [31:0] d;
    wr(A_INTEN, 32'h7);
    wr(A_WRCNT, 32'd1);
    wait_idle();
    rd(A_RDCNT, d); chk("R2 read count", d, 32'd1);
    chk("R2 hdr word addr", flog[0], 32'h40);
    chk("R2 ptr word addr", flog[1], 32'h44);
    chk("R2 mover count", 32'(mvl_n), 32'd1);
    chk("R2 mover hdr", mvl_hdr[0], 32'h2000_0010);
    chk("R2 mover buf", mvl_buf[0], 32'h0000_1000);
    rd(A_INTST, d); chk("R4 done only", d, 32'h1);
    chk("R10 irq raised", {31'd0, irq}, 32'h1);
    wr(A_INTST, 32'h7);
    rd(A_INTST, d); chk("R10 w1c cleared", d, 32'h0);
    chk("R10 irq dropped", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(A_WRCNT, 32'd6);
    wait_idle();
    rd(A_RDCNT, d); chk("R4 read count reaches 6", d, 32'd6);
    chk("R3 mover count skips link", 32'(mvl_n), 32'd5);
    chk("R3 order slot1", mvl_buf[1], 32'h1100);
    chk("R3 order slot2", mvl_buf[2], 32'h1200);
    chk("R3 wrapped slot0", mvl_buf[3], 32'h1000);
    chk("R3 wrapped slot1", mvl_buf[4], 32'h1100);
    chk("R3 link fetch", flog[6], 32'h58);
    chk("R3 aligned target", flog[8], 32'h40);
    rd(A_INTST, d); chk("R5 finish flag and done", d, 32'h3);
    wr(A_INTST, 32'h7);
  endtask

  task automatic t_doorbell_live();
    logic [31:0] d, a0;
    mem_lat = 6;
    wr(A_WRCNT, 32'd7);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      if (mem_req) break;
    end
    a0 = mem_addr;
    wr(A_WRCNT, 32'd9);
    #1;
    chk("R9 request kept", {31'd0, mem_req}, 32'h1);
    chk("R9 address kept", mem_addr, a0);
    wait_idle();
    mem_lat = 2;
    rd(A_RDCNT, d); chk("R9 ran to new count", d, 32'd9);
    chk("R9 mover count", 32'(mvl_n), 32'd7);
    chk("R9 slot2 moved", mvl_buf[5], 32'h1200);
    chk("R9 slot0 after link", mvl_buf[6], 32'h1000);
    wr(A_INTST, 32'h7);
  endtask

  task automatic t_suspend();
    logic [31:0] d;
    mv_lat = 20;
    wr(A_WRCNT, 32'd12);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (mv_valid) break;
    end
    wr(A_CTRL, 32'h2);
    wait_idle();
    mv_lat = 2;
    rd(A_RDCNT, d); chk("R8 one descriptor retired", d, 32'd10);
    rd(A_STAT, d);  chk("R8 suspended status", d, 32'h4);
    rd(A_INTST, d); chk("R8 no done event", d, 32'h0);
    wr(A_WRCNT, 32'd12);
    wait_idle();
    rd(A_RDCNT, d); chk("R8 resumed", d, 32'd12);
    rd(A_STAT, d);  chk("R8 status after resume", d, 32'h0);
    rd(A_INTST, d); chk("R8 done after resume", d, 32'h3);
    wr(A_INTST, 32'h7);
  endtask

  task automatic t_mover_error();
    logic [31:0] d;
    bit saw_req;
    force_err = 1;
    wr(A_WRCNT, 32'd13);
    wait_idle();
    force_err = 0;
    rd(A_STAT, d);  chk("R6 abort status", d, 32'h2);
    rd(A_INTST, d); chk("R6 error event", d, 32'h4);
    rd(A_RDCNT, d); chk("R6 count held", d, 32'd12);
    wr(A_WRCNT, 32'd14);
    saw_req = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (mem_req) saw_req = 1;
    end
    chk("R6 no fetch while aborted", {31'd0, saw_req}, 32'h0);
    rd(A_RDCNT, d); chk("R6 count still held", d, 32'd12);
    wr(A_INTEN, 32'h3);
    #1; chk("R10 error masked", {31'd0, irq}, 32'h0);
    wr(A_INTEN, 32'h4);
    #1; chk("R10 error enabled", {31'd0, irq}, 32'h1);
    wr(A_INTEN, 32'h7);
  endtask

  task automatic t_init();
    logic [31:0] d;
    int f0, m0;
    wr(A_CTRL, 32'h1);
    rd(A_STAT, d);  chk("R7 status cleared", d, 32'h0);
    rd(A_RDCNT, d); chk("R7 read count cleared", d, 32'h0);
    rd(A_WRCNT, d); chk("R7 write count cleared", d, 32'h0);
    rd(A_BASE, d);  chk("R7 base cleared", d, 32'h0);
    wr(A_INTST, 32'h7);
    wr(A_BASE, 32'h40);
    f0 = flog_n; m0 = mvl_n;
    wr(A_WRCNT, 32'd1);
    wait_idle();
    rd(A_RDCNT, d); chk("R7 restarted", d, 32'd1);
    chk("R7 fetch from base", flog[f0], 32'h40);
    chk("R7 moved slot0", mvl_buf[m0], 32'h1000);
    wr(A_INTST, 32'h7);
  endtask

  task automatic t_bad_type();
    logic [31:0] d;
    int m0;
    m0 = mvl_n;
    mem[18] = 32'hA000_0020;
    wr(A_WRCNT, 32'd2);
    wait_idle();
    rd(A_STAT, d);  chk("R6 bad type aborts", d, 32'h2);
    rd(A_RDCNT, d); chk("R6 bad type count held", d, 32'd1);
    rd(A_INTST, d); chk("R6 bad type error", d, 32'h4);
    chk("R6 bad type not moved", 32'(mvl_n), 32'(m0));
    mem[18] = 32'h2000_0020;
    wr(A_CTRL, 32'h1);
    wr(A_INTST, 32'h7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    load_ring();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_base_align();
    t_single();
    t_wrap();
    t_doorbell_live();
    t_suspend();
    t_mover_error();
    t_init();
    t_bad_type();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule